// File: doc/BRIEF.md
# Dual-Mode Oversampling Tick Generator

This block produces the 16x oversampling strobe that paces an asynchronous serial transmitter and receiver. One rate value feeds two engines, and a mode pin picks which engine drives the output. The integer divider emits one tick every `rate` clocks. The fractional engine adds `rate` to a 16-bit phase accumulator on every clock and emits a tick on each carry out of the top bit. In divider mode the value to load is the input clock divided by sixteen times the bit rate. In accumulator mode it is the bit rate times 16 times 65536, divided by the input clock. The fractional engine is the better choice above 19200 bit/s, where integer rounding would distort the rate. Below that rate the divider is the better choice.

The mode and run pins come from a control word decoded outside the block, where mode sits at bit 12 and run at bit 7. The rate value comes from a register at offset 0x00 of the peripheral map. The block has no data stream and no handshake. It takes three plain control inputs and drives one pulse output, `tick_o`, which is high for one clock per tick. At high rates in accumulator mode, pulses can fall in adjacent clocks. While run is low, both engines are held at zero, so every start follows the same sequence.

Top module: `baud_tick_gen`

## Requirements
- R1: In divider mode (`mode_i` = 0) with `rate_i` = N > 0, counting the first rising edge that sees `run_i` high as edge 1, `tick_o` is high after edge 1+N and then after every further N edges, and low otherwise.
- R2: In divider mode, a change of `rate_i` while running does not alter the count in progress. The new value is used from the next reload.
- R3: In accumulator mode (`mode_i` = 1) with `rate_i` = K, `tick_o` is high after edge j exactly when floor(j·K/65536) differs from floor((j−1)·K/65536), counting the first running edge as j = 1.
- R4: In accumulator mode, a change of `rate_i` takes effect on the very next edge. The accumulator keeps its phase and adds the new value from that edge on.
- R5: A `rate_i` of zero produces no tick in either mode.
- R6: After an edge that sees `run_i` low, `tick_o` is low and both engines are cleared, so a restart repeats the R1 or R3 sequence from zero.
- R7: The engine not selected by `mode_i` is held at zero. After a change of `mode_i` while running, the newly selected engine starts its sequence from zero, and `tick_o` is low in the first cycle after the change.
- R8: While `rst_n` is low, `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables tick generation; low clears both engines |
| mode_i | input | 1 | 0 = integer divider, 1 = phase accumulator |
| rate_i | input | 16 | Divider reload value or accumulator increment |
| tick_o | output | 1 | Oversampling tick, high for one clock per tick |

## Verification
Every cycle, the assertions check the following:
- A divider tick is never followed by a second tick while the reloaded count is above one.
- A zero rate leaves both engines still.
- A low run or a deselected mode leaves an engine cleared and silent.
- A mode change never produces a tick in the following cycle.

Only the bench scenarios can show the following:
- The exact tick positions for a given rate.
- The deferred effect of a divider rate change compared with the immediate effect in the accumulator.
- The fractional tick density of the accumulator.
- The repeatability of a restart.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef enum logic {
    TICK_MODE_DIV = 1'b0,
    TICK_MODE_ACC = 1'b1
  } tick_mode_e;

  localparam int unsigned RATE_W_DEFAULT = 16;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] reload_i,
  output logic              tick_o
);
  localparam logic [RATE_W-1:0] CNT_ZERO = '0;
  localparam logic [RATE_W-1:0] CNT_ONE  = {{(RATE_W-1){1'b0}}, 1'b1};

  logic [RATE_W-1:0] cnt_q;
  logic              tick_q;

  // Reload whenever the count is at zero or one. The tick marks the count expiring at one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_ZERO;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= CNT_ZERO;
      tick_q <= 1'b0;
    end else if (cnt_q <= CNT_ONE) begin
      cnt_q  <= reload_i;
      tick_q <= (cnt_q == CNT_ONE);
    end else begin
      cnt_q  <= cnt_q - CNT_ONE;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R1: a tick is followed by a quiet cycle while the loaded count exceeds one.
  assert_div_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_q && cnt_q > CNT_ONE) |=> !tick_q);

  // R5: a zero reload from an empty count keeps the divider silent and empty.
  assert_div_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && reload_i == CNT_ZERO && cnt_q == CNT_ZERO) |=> (!tick_q && cnt_q == CNT_ZERO));

  // R6: a disabled divider is cleared on the next edge.
  assert_div_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == CNT_ZERO && !tick_q));
endmodule

// File: rtl/tick_phase_acc.sv
module tick_phase_acc #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] inc_i,
  output logic              tick_o
);
  localparam int unsigned SUM_W = RATE_W + 1;

  logic [RATE_W-1:0] acc_q;
  logic              tick_q;
  logic [SUM_W-1:0]  sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  // The carry out of the top bit becomes the tick. The phase wraps modulo 2^RATE_W.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[RATE_W-1:0];
      tick_q <= sum[RATE_W];
    end
  end

  assign tick_o = tick_q;

  // R5: a zero increment neither moves the phase nor ticks.
  assert_acc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && inc_i == '0) |=> (!tick_q && $stable(acc_q)));

  // R6: a disabled accumulator is cleared on the next edge.
  assert_acc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (acc_q == '0 && !tick_q));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned RATE_W = RATE_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  tick_mode_e mode;
  logic       div_en, acc_en;
  logic       div_tick, acc_tick;

  assign mode   = tick_mode_e'(mode_i);
  assign div_en = run_i && (mode == TICK_MODE_DIV);
  assign acc_en = run_i && (mode == TICK_MODE_ACC);

  tick_divider #(.RATE_W(RATE_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (div_en),
    .reload_i (rate_i),
    .tick_o   (div_tick)
  );

  tick_phase_acc #(.RATE_W(RATE_W)) i_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (acc_en),
    .inc_i  (rate_i),
    .tick_o (acc_tick)
  );

  always_comb begin
    unique case (mode)
      TICK_MODE_ACC: tick_o = acc_tick;
      default:       tick_o = div_tick;
    endcase
  end

  // R6: no tick in the cycle after an edge that saw run low.
  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_o);

  // R7: a freshly selected engine starts from zero, so no tick follows a mode change.
  assert_mode_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != $past(mode_i)) |-> !tick_o);

  // R8: the output is low while reset is held.
  always_comb begin
    if (!rst_n) assert_reset_low_R8: assert (!tick_o);
  end
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] rate_i = '0;
  logic        tick_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_i(mode_i),
    .rate_i(rate_i), .tick_o(tick_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected divider tick at sample j (edge 1 loads), rate n1 until the first reload, n2 after.
  function automatic bit div_exp(int j, int n1, int n2);
    if (n1 == 0) return 1'b0;
    if (j == 1 + n1) return 1'b1;
    if (j > 1 + n1 && n2 != 0) return ((j - 1 - n1) % n2) == 0;
    return 1'b0;
  endfunction

  function automatic bit acc_exp(longint s_now, longint s_prev);
    return (s_now >> 16) != (s_prev >> 16);
  endfunction

  task automatic stop_run();
    run_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Divider run; rate switches from n1 to n2 after sample sw.
  task automatic run_div(input string req, input int n1, input int n2, input int sw, input int len);
    int errs = 0;
    int first_bad = 0;
    bit first_exp = 1'b0;
    stop_run();
    mode_i = 1'b0;
    rate_i = 16'(n1);
    run_i = 1'b1;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      if (tick_o !== div_exp(j, n1, n2)) begin
        if (errs == 0) begin
          first_bad = j;
          first_exp = div_exp(j, n1, n2);
        end
        errs++;
      end
      if (j == sw) rate_i = 16'(n2);
    end
    check(errs == 0, req, first_bad, int'(first_exp));
  endtask

  // Accumulator run; increment switches from k1 to k2 after sample sw.
  task automatic run_acc(input string req, input int k1, input int k2, input int sw, input int len);
    int errs = 0;
    int first_bad = 0;
    longint s_prev = 0;
    longint s_now = 0;
    int cur = k1;
    stop_run();
    mode_i = 1'b1;
    rate_i = 16'(k1);
    run_i = 1'b1;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      s_now = s_prev + longint'(cur);
      if (tick_o !== acc_exp(s_now, s_prev)) begin
        if (errs == 0) first_bad = j;
        errs++;
      end
      s_prev = s_now;
      if (j == sw) begin
        cur = k2;
        rate_i = 16'(k2);
      end
    end
    check(errs == 0, req, first_bad, 0);
  endtask

  task automatic expect_quiet(input string req, input int len);
    int hits = 0;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      if (tick_o !== 1'b0) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8: output low during reset, even with run high.
    run_i = 1'b1;
    rate_i = 16'd1;
    repeat (3) @(negedge clk);
    check(tick_o === 1'b0, "R8", int'(tick_o), 0);
    run_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: directed and random divider rates.
    run_div("R1", 1, 1, 0, 12);
    run_div("R1", 2, 2, 0, 12);
    run_div("R1", 65535, 65535, 0, 70000);
    for (int i = 0; i < 6; i++) begin
      int n = 1 + int'($urandom_range(0, 40));
      run_div("R1", n, n, 0, 5 * n + 3);
    end

    // R2: a rate change mid-count applies only from the next reload.
    run_div("R2", 7, 3, 1, 30);
    run_div("R2", 4, 9, 2, 40);

    // R3: accumulator tick density, directed and random.
    run_acc("R3", 16'h8000, 16'h8000, 0, 20);
    run_acc("R3", 16'hFFFF, 16'hFFFF, 0, 40);
    run_acc("R3", 1, 1, 0, 65600);
    for (int i = 0; i < 6; i++) begin
      int k = 1 + int'($urandom_range(0, 65534));
      run_acc("R3", k, k, 0, 300);
    end

    // R4: an increment change applies on the next edge, keeping the phase.
    run_acc("R4", 16'h3000, 16'hC000, 5, 40);
    run_acc("R4", 16'hF000, 16'h0100, 3, 600);

    // R5: a zero rate gives no ticks in either mode.
    stop_run();
    mode_i = 1'b0; rate_i = '0; run_i = 1'b1;
    expect_quiet("R5", 50);
    stop_run();
    mode_i = 1'b1; rate_i = '0; run_i = 1'b1;
    expect_quiet("R5", 50);

    // R6: stopping silences the output, and a restart repeats the sequence.
    run_div("R6", 3, 3, 0, 5);
    run_i = 1'b0;
    expect_quiet("R6", 8);
    run_div("R6", 3, 3, 0, 12);
    run_acc("R6", 16'hE000, 16'hE000, 0, 7);
    run_i = 1'b0;
    expect_quiet("R6", 4);
    run_acc("R6", 16'hE000, 16'hE000, 0, 20);

    // R7: switching from the divider to the accumulator starts the accumulator from zero.
    begin
      int errs = 0;
      longint s_prev = 0;
      longint s_now = 0;
      stop_run();
      mode_i = 1'b0; rate_i = 16'd5; run_i = 1'b1;
      repeat (8) @(negedge clk);
      mode_i = 1'b1; rate_i = 16'hA000;
      for (int j = 1; j <= 30; j++) begin
        @(negedge clk);
        s_now = s_prev + 64'h0000_A000;
        if (tick_o !== acc_exp(s_now, s_prev)) errs++;
        s_prev = s_now;
      end
      check(errs == 0, "R7", errs, 0);
      // Switching back restarts the divider from zero.
      mode_i = 1'b0; rate_i = 16'd4;
      errs = 0;
      for (int j = 1; j <= 20; j++) begin
        @(negedge clk);
        if (tick_o !== div_exp(j, 4, 4)) errs++;
      end
      check(errs == 0, "R7", errs, 0);
    end

    stop_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule